// File: doc/BRIEF.md
# Indexed Accumulator Memory Access Unit

This block owns a base-address register and moves data between an accumulator and a 32-bit-wide data memory. A client presents one operation per cycle on a small request port. The operation either copies the accumulator into the base register, or it starts an indexed access at the base register plus an 8-bit unsigned offset. Word accesses multiply the offset by four. Byte accesses use the offset as given.

The address, byte-enables, write data and strobes go to the memory in the same cycle as the request. The memory is assumed to be synchronous, with one cycle of read latency. On the next cycle the unit returns the load result with a one-cycle valid pulse. A byte load selects one lane of the returned word, in little-endian order, and sign-extends it to 32 bits. A byte store places the low byte of the accumulator on every lane and enables only the addressed lane.

Top module: `ixm_unit`

## Requirements
- R1: When `req_valid` is high with opcode 1 (set-base), `base_q` equals `acc_in` after the next clock edge, and no memory strobe is raised in that cycle.
- R2: A word load (opcode 2) drives `mem_re`=1, `mem_we`=0 and `mem_be`=0. It drives `mem_addr` with base + 4*offset, low two bits cleared, in the same cycle.
- R3: The cycle after a word load, `ld_data` equals the full 32-bit word the memory returned for that address.
- R4: A word store (opcode 3) drives `mem_we`=1, `mem_re`=0, `mem_be`=4'b1111, `mem_wdata`=`acc_in`, and `mem_addr` as in R2.
- R5: A byte load (opcode 4) reads the word that holds byte address base + offset. The next cycle, `ld_data` is the byte in lane (address mod 4), sign-extended from its bit 7. Lane k is memory bits 8k+7..8k.
- R6: A byte store (opcode 5) drives `mem_we`=1. It asserts only `mem_be` bit (address mod 4) and places `acc_in[7:0]` in every lane of `mem_wdata`. Only that byte of memory changes.
- R7: The offset is unsigned (0..255), and the address sum wraps modulo 2^32.
- R8: For word accesses the low two bits of the sum are dropped. `mem_addr[1:0]` is always 0 while either strobe is high.
- R9: `ld_valid` is high exactly in the cycle after a load request (opcode 2 or 4) and low in every other cycle.
- R10: With `req_valid` low, opcode 0, or a reserved opcode 6 or 7, no strobe is raised, `base_q` keeps its value, and no `ld_valid` follows.
- R11: While `rst_n` is low, and after its release until the first request, `base_q`=0, `ld_valid`=0, `mem_we`=0 and `mem_re`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier |
| req_op | input | 3 | Opcode: 0 none, 1 set-base, 2 word load, 3 word store, 4 byte load, 5 byte store |
| req_ofs | input | 8 | Unsigned offset |
| acc_in | input | 32 | Accumulator value (store data / new base) |
| base_q | output | 32 | Current base-address register |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Byte-enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| ld_valid | output | 1 | Load result valid pulse |
| ld_data | output | 32 | Load result for the accumulator |

## Verification
The bench aims at the four byte lanes on both loads and stores. A unit with the lane order reversed, or with the wrong enable raised, would corrupt a neighbouring byte, and later word reads would expose it. Negative byte values are loaded to catch zero-extension in place of sign extension. An offset of 255 on a base near the top of the address space checks that the sum wraps and that the offset is not treated as signed. Misaligned bases on word accesses check that the low bits are dropped, not carried into the address. Reserved opcodes and idle cycles check that no spurious strobe or `ld_valid` pulse appears.

// File: rtl/ixm_pkg.sv
package ixm_pkg;

  localparam int DW = 32;
  localparam int OW = 8;
  localparam int BW = 8;
  localparam int NL = DW / BW;
  localparam int LW = $clog2(NL);

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_SETAR = 3'd1,
    OP_LDW   = 3'd2,
    OP_STW   = 3'd3,
    OP_LDB   = 3'd4,
    OP_STB   = 3'd5
  } op_e;

  function automatic logic [DW-1:0] zext_ofs(input logic [OW-1:0] ofs);
    return {{(DW-OW){1'b0}}, ofs};
  endfunction

  function automatic logic [DW-1:0] word_ea(input logic [DW-1:0] base,
                                            input logic [OW-1:0] ofs);
    return base + (zext_ofs(ofs) << LW);
  endfunction

  function automatic logic [DW-1:0] byte_ea(input logic [DW-1:0] base,
                                            input logic [OW-1:0] ofs);
    return base + zext_ofs(ofs);
  endfunction

  function automatic logic [DW-1:0] align_word(input logic [DW-1:0] a);
    return {a[DW-1:LW], {LW{1'b0}}};
  endfunction

  function automatic logic [NL-1:0] lane_mask(input logic [LW-1:0] lane);
    logic [NL-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] lane_sext(input logic [DW-1:0] w,
                                              input logic [LW-1:0] lane);
    logic [BW-1:0] b;
    b = w[lane*BW +: BW];
    return {{(DW-BW){b[BW-1]}}, b};
  endfunction

endpackage

// File: rtl/ixm_base_reg.sv
module ixm_base_reg
  import ixm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load_en) q <= din;
  end

  p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));

  p_base_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q == $past(din)));

endmodule

// File: rtl/ixm_addr_gen.sv
module ixm_addr_gen
  import ixm_pkg::*;
(
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [OW-1:0] req_ofs,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] acc,
  output logic [DW-1:0] mem_addr,
  output logic [NL-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          rd_byte,
  output logic [LW-1:0] rd_lane
);

  logic is_ldw, is_stw, is_ldb, is_stb, is_byte;
  logic [DW-1:0] ea;

  always_comb begin
    is_ldw  = req_valid && (req_op == OP_LDW);
    is_stw  = req_valid && (req_op == OP_STW);
    is_ldb  = req_valid && (req_op == OP_LDB);
    is_stb  = req_valid && (req_op == OP_STB);
    is_byte = is_ldb || is_stb;
    ea      = is_byte ? byte_ea(base, req_ofs) : word_ea(base, req_ofs);
    mem_addr = align_word(ea);
    rd_lane  = ea[LW-1:0];
    rd_byte  = is_ldb;
    mem_we   = is_stw || is_stb;
    mem_re   = is_ldw || is_ldb;
    if (is_stw)      mem_be = '1;
    else if (is_stb) mem_be = lane_mask(ea[LW-1:0]);
    else             mem_be = '0;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign mem_wdata[g*BW +: BW] = is_stb ? acc[BW-1:0] : acc[g*BW +: BW];
  end

endmodule

// File: rtl/ixm_load_return.sv
module ixm_load_return
  import ixm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          rd_byte,
  input  logic [LW-1:0] rd_lane,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);

  logic          pend_v;
  logic          pend_b;
  logic [LW-1:0] pend_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_b    <= 1'b0;
      pend_lane <= '0;
    end else begin
      pend_v    <= rd_fire;
      pend_b    <= rd_fire && rd_byte;
      pend_lane <= rd_lane;
    end
  end

  assign ld_valid = pend_v;
  assign ld_data  = pend_b ? lane_sext(mem_rdata, pend_lane) : mem_rdata;

  p_pulse_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ld_valid);

  p_no_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !ld_valid);

endmodule

// File: rtl/ixm_unit.sv
module ixm_unit
  import ixm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [7:0]    req_ofs,
  input  logic [31:0]   acc_in,
  output logic [31:0]   base_q,
  output logic [31:0]   mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data
);

  logic          set_base;
  logic          rd_byte;
  logic [LW-1:0] rd_lane;

  assign set_base = req_valid && (req_op == OP_SETAR);

  ixm_base_reg u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(set_base),
    .din    (acc_in),
    .q      (base_q)
  );

  ixm_addr_gen u_agen (
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_ofs  (req_ofs),
    .base     (base_q),
    .acc      (acc_in),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .rd_byte  (rd_byte),
    .rd_lane  (rd_lane)
  );

  ixm_load_return u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (mem_re),
    .rd_byte  (rd_byte),
    .rd_lane  (rd_lane),
    .mem_rdata(mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr[1:0] == 2'b00));

  p_read_no_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_be == 4'b0000));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_be == 4'b1111) || ($countones(mem_be) == 1)));

  p_setbase_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_base |-> (!mem_we && !mem_re));

endmodule

// File: tb/ixm_unit_tb_top.sv
`timescale 1ns/1ps
module ixm_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_ofs = 8'd0;
  logic [31:0] acc_in = 32'd0;
  logic [31:0] base_q, mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, ld_valid;
  logic [31:0] mem_rdata = 32'd0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ixm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ofs(req_ofs), .acc_in(acc_in), .base_q(base_q), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // memory the block talks to: word array, byte-enabled writes, 1-cycle read
  logic [31:0] bus_mem [bit [29:0]];
  always @(posedge clk) begin
    if (mem_we) begin
      logic [31:0] w;
      w = bus_mem.exists(mem_addr[31:2]) ? bus_mem[mem_addr[31:2]] : 32'd0;
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
      bus_mem[mem_addr[31:2]] = w;
    end
    if (mem_re)
      mem_rdata <= bus_mem.exists(mem_addr[31:2]) ? bus_mem[mem_addr[31:2]] : 32'd0;
  end

  // reference model: byte-granular memory, base register, pending load
  logic [7:0]  ref_mem [bit [31:0]];
  logic [31:0] m_base = 32'd0;
  bit          m_pend = 1'b0;
  logic [31:0] m_pend_data = 32'd0;

  function automatic logic [7:0] rd_byte_ref(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'd0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [7:0] ofs, logic [31:0] acc);
    logic [31:0] sum, waddr;
    logic [31:0] e_wd;
    logic [3:0]  e_be;
    bit          e_we, e_re, is_word, is_byte, live;
    string       r;
    req_valid = v; req_op = op; req_ofs = ofs; acc_in = acc;
    #2;
    live    = v && (op >= 3'd1) && (op <= 3'd5);
    is_word = v && (op == 3'd2 || op == 3'd3);
    is_byte = v && (op == 3'd4 || op == 3'd5);
    sum     = is_byte ? m_base + 32'(ofs) : m_base + 32'(ofs) * 32'd4;
    waddr   = sum & 32'hFFFF_FFFC;
    e_we    = v && (op == 3'd3 || op == 3'd5);
    e_re    = v && (op == 3'd2 || op == 3'd4);
    e_be    = (v && op == 3'd3) ? 4'hF : (v && op == 3'd5) ? (4'd1 << sum[1:0]) : 4'h0;
    e_wd    = (v && op == 3'd5) ? {4{acc[7:0]}} : acc;
    r = !live ? "R10" : (op == 3'd1) ? "R1" : (op == 3'd2) ? "R2" :
        (op == 3'd3) ? "R4" : (op == 3'd4) ? "R5" : "R6";
    chk(r, "mem_we", 32'(mem_we), 32'(e_we));
    chk(r, "mem_re", 32'(mem_re), 32'(e_re));
    if (is_word || is_byte) chk(r, "mem_addr(R7/R8)", mem_addr, waddr);
    if (e_we || e_re) chk(r, "mem_be", 32'(mem_be), 32'(e_be));
    if (e_we) chk(r, "mem_wdata", mem_wdata, e_wd);
    // update reference
    if (e_we && op == 3'd3)
      for (int k = 0; k < 4; k++) ref_mem[waddr + 32'(k)] = acc[8*k +: 8];
    if (e_we && op == 3'd5) ref_mem[sum] = acc[7:0];
    @(negedge clk);
    // load return from previous request
    if (e_re) begin
      if (op == 3'd2)
        m_pend_data = {rd_byte_ref(waddr+3), rd_byte_ref(waddr+2),
                       rd_byte_ref(waddr+1), rd_byte_ref(waddr)};
      else
        m_pend_data = 32'($signed(rd_byte_ref(sum)));
    end
    chk("R9", "ld_valid", 32'(ld_valid), 32'(e_re));
    if (e_re) chk(op == 3'd2 ? "R3" : "R5", "ld_data", ld_data, m_pend_data);
    if (v && op == 3'd1) m_base = acc;
    chk(live ? "R1" : "R10", "base_q", base_q, m_base);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "base_q", base_q, 32'd0);
    chk("R11", "ld_valid", 32'(ld_valid), 32'd0);
    chk("R11", "strobes", 32'({mem_we, mem_re}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "base_q after release", base_q, 32'd0);
    chk("R11", "ld_valid after release", 32'(ld_valid), 32'd0);

    step(1, 3'd1, 8'd0, 32'h0000_1000);          // R1
    step(1, 3'd3, 8'd0, 32'h1122_3344);          // R4
    step(1, 3'd3, 8'd3, 32'hA5A5_5A5A);          // R4 offset scaling
    step(1, 3'd2, 8'd0, 32'h0);                  // R2/R3
    step(1, 3'd5, 8'd1, 32'hFFFF_FF80);          // R6 lane 1
    step(1, 3'd5, 8'd3, 32'h0000_00FE);          // R6 lane 3
    step(1, 3'd4, 8'd1, 32'h0);                  // R5 negative byte
    step(1, 3'd4, 8'd0, 32'h0);                  // R5 positive byte 0x44
    step(1, 3'd4, 8'd2, 32'h0);                  // R5 lane 2
    step(1, 3'd2, 8'd0, 32'h0);                  // R3 merged word
    step(0, 3'd2, 8'd0, 32'h0);                  // R10 invalid
    step(1, 3'd6, 8'd0, 32'hDEAD_BEEF);          // R10 reserved
    step(1, 3'd7, 8'd0, 32'hDEAD_BEEF);          // R10 reserved
    step(1, 3'd0, 8'd5, 32'hDEAD_BEEF);          // R10 none
    step(1, 3'd2, 8'd0, 32'h0);                  // R10 memory untouched
    step(1, 3'd1, 8'd0, 32'h0000_2003);          // R8 misaligned base
    step(1, 3'd3, 8'd1, 32'h0BAD_F00D);          // R8 addr 0x2004
    step(1, 3'd2, 8'd1, 32'h0);                  // R8
    step(1, 3'd5, 8'd1, 32'h0000_0081);          // R6 byte addr 0x2004 lane 0
    step(1, 3'd4, 8'd1, 32'h0);                  // R5
    step(1, 3'd1, 8'd0, 32'hFFFF_FFFC);          // R7 wrap
    step(1, 3'd3, 8'd1, 32'hCAFE_0001);          // R7 addr 0
    step(1, 3'd5, 8'd255, 32'h0000_00C3);        // R7 byte addr 0xFB
    step(1, 3'd4, 8'd255, 32'h0);                // R7
    step(1, 3'd2, 8'd255, 32'h0);                // R7 word addr 0x3F8
    step(1, 3'd2, 8'd1, 32'h0);                  // R7 word from addr 0
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd1)
        step(1, op, 8'd0, 32'h0000_4000 + 32'($urandom_range(0, 63)));
      else
        step($urandom_range(0, 7) != 0, op, 8'($urandom_range(0, 15)), $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule